// File: doc/BRIEF.md
# ADC status flag register

This block keeps the 16-bit status word of a two-channel sigma-delta ADC subsystem. One channel is the primary and the other the auxiliary. The conversion engine sends it single-cycle event strobes: calibration done, a result write per channel with underrange/overrange qualifiers, a live accumulator value with its threshold, and a periodic coarse overrange sample. The bus side sends strobes for a mode-register write, a read of each data register and a gain change, plus the level of the overrange-detect enable.

Each status bit follows its own set and clear rule. Some bits are sticky and some are live. The block also holds the two channel data registers and clamps each stored result to a full-scale value when the engine flags a range error. The primary threshold bit can be qualified by a count of consecutive exceedances.

All flags are registered. An event sampled on a clock edge is visible on `status_o` right after that edge. When a set and a clear for the same bit arrive together, the set wins.

Top module: `adc_status_reg`

## Requirements
- R1: Bit 15 (calibration done) sets on `cal_done_i` and clears on `mode_wr_i`. When both arrive in the same cycle, the bit ends set.
- R2: A result write stores the input value when it is in range. It stores 16'h8000 when underrange and 16'h7FFF when overrange. Underrange takes priority when both qualifiers are high. This holds for each channel's data output.
- R3: Bit 12 (primary) and bit 13 (auxiliary) set on an out-of-range write to their channel. They clear on the next in-range write to that channel, and nothing else changes them.
- R4: Bit 6 is high exactly when, on the previous edge, `acc_val_i` was greater than `acc_thr_i`, compared unsigned. It has no memory.
- R5: Bit 0 sets on any primary result write or on `cal_done_i`, and clears on `pri_rd_i`. A set in the same cycle as the read wins.
- R6: Bit 1 sets on any auxiliary result write or on `cal_done_i`. It clears only on a `pri_rd_i` that comes in a later cycle than an `aux_rd_i`. A primary read with no auxiliary read before it, or an auxiliary read in the same cycle as the primary read, leaves the bit set. A set wins over the clear.
- R7: With `cmp_en_i` high and `cnt_en_i` low, each primary write sets bit 4 to 1 if the magnitude of the stored signed value exceeds `thr_val_i`, and to 0 otherwise. With `cmp_en_i` low, bit 4 is 0.
- R8: With `cmp_en_i` and `cnt_en_i` high, bit 4 sets on the primary write where the run of consecutive exceeding writes reaches `thr_cnt_i`. It stays set on further exceeding writes. A non-exceeding write zeroes the run and clears the bit.
- R9: Bit 3 sets when `ovr_en_i`, `ovr_tick_i` and `ovr_sample_i` are all high. Once set it holds until `ovr_en_i` is low or `gain_wr_i` pulses. A set wins over a gain write in the same cycle.
- R10: Bits 14, 11 to 7, 5 and 2 (mask 16'h4FA4) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cal_done_i | input | 1 | Calibration cycle finished |
| mode_wr_i | input | 1 | Mode register written |
| pri_wr_i | input | 1 | Primary result write strobe |
| pri_under_i | input | 1 | Primary result underrange |
| pri_over_i | input | 1 | Primary result overrange |
| pri_data_i | input | 16 | Primary raw result, signed |
| aux_wr_i | input | 1 | Auxiliary result write strobe |
| aux_under_i | input | 1 | Auxiliary result underrange |
| aux_over_i | input | 1 | Auxiliary result overrange |
| aux_data_i | input | 16 | Auxiliary raw result, signed |
| pri_rd_i | input | 1 | Primary data register read |
| aux_rd_i | input | 1 | Auxiliary data register read |
| acc_val_i | input | 16 | Primary accumulator value |
| acc_thr_i | input | 16 | Accumulator threshold |
| cmp_en_i | input | 1 | Primary comparator enable |
| cnt_en_i | input | 1 | Consecutive-count qualifier enable |
| thr_val_i | input | 16 | Primary magnitude threshold |
| thr_cnt_i | input | 8 | Required consecutive exceedances |
| ovr_en_i | input | 1 | Coarse overrange detect enable |
| ovr_tick_i | input | 1 | Periodic overrange sample tick |
| ovr_sample_i | input | 1 | Coarse overrange detector output |
| gain_wr_i | input | 1 | Primary gain setting written |
| pri_dat_o | output | 16 | Stored primary result |
| aux_dat_o | output | 16 | Stored auxiliary result |
| status_o | output | 16 | Status word |

## Verification
A table of result writes is applied to both channels. It covers in-range, underrange, overrange and both-qualifier cases, which separates the clamp values, the underrange priority and the clearing of the error bit on an in-range write. The magnitude comparator is driven with values above, equal to and below the threshold, and with a negative value and the clamped minimum. This exposes a compare that is off by one or ignores the sign. Runs of exceeding writes, cut short by a small value, show whether the consecutive counter saturates and resets. Read orderings of the two data registers, and same-cycle set/clear collisions, separate the ordered-read rule and the set-wins rule from simpler clear logic.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned B_CAL  = 15;
  localparam int unsigned B_AERR = 13;
  localparam int unsigned B_PERR = 12;
  localparam int unsigned B_ACC  = 6;
  localparam int unsigned B_THR  = 4;
  localparam int unsigned B_OVR  = 3;
  localparam int unsigned B_ARDY = 1;
  localparam int unsigned B_PRDY = 0;
  localparam int unsigned N_CH   = 2;
  localparam int unsigned CH_PRI = 0;
  localparam int unsigned CH_AUX = 1;

  typedef enum logic [1:0] {
    RNG_OK,
    RNG_UNDER,
    RNG_OVER
  } rng_e;
endpackage

// File: rtl/adc_result_chan.sv
module adc_result_chan
  import adc_stat_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          under_i,
  input  logic          over_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] clamp_o,
  output logic [DW-1:0] dat_o,
  output logic          err_o
);
  localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};

  rng_e rng;

  always_comb begin
    if (under_i)     rng = RNG_UNDER;
    else if (over_i) rng = RNG_OVER;
    else             rng = RNG_OK;
  end

  always_comb begin
    unique case (rng)
      RNG_UNDER: clamp_o = NEG_FS;
      RNG_OVER:  clamp_o = POS_FS;
      default:   clamp_o = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_o <= '0;
      err_o <= 1'b0;
    end else if (wr_i) begin
      dat_o <= clamp_o;
      err_o <= (rng != RNG_OK);
    end
  end
endmodule

// File: rtl/adc_thresh_qual.sv
module adc_thresh_qual #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          cmp_en_i,
  input  logic          cnt_en_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] thr_i,
  input  logic [CW-1:0] cnt_lim_i,
  output logic          flag_o
);
  logic [DW-1:0] mag;
  logic          exceed;
  logic [CW-1:0] run_q, run_nxt;

  // two's complement magnitude; most negative value maps to 2^(DW-1)
  assign mag     = val_i[DW-1] ? (~val_i + DW'(1)) : val_i;
  assign exceed  = mag > thr_i;
  assign run_nxt = (run_q == cnt_lim_i) ? run_q : run_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      flag_o <= 1'b0;
    end else if (!cmp_en_i) begin
      run_q  <= '0;
      flag_o <= 1'b0;
    end else if (wr_i) begin
      if (!exceed) begin
        run_q  <= '0;
        flag_o <= 1'b0;
      end else if (cnt_en_i) begin
        run_q  <= run_nxt;
        flag_o <= (run_nxt == cnt_lim_i);
      end else begin
        run_q  <= '0;
        flag_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_ovr_detect.sv
module adc_ovr_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic sample_i,
  input  logic gain_wr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         flag_o <= 1'b0;
    else if (en_i && tick_i && sample_i) flag_o <= 1'b1;
    else if (!en_i || gain_wr_i)         flag_o <= 1'b0;
  end
endmodule

// File: rtl/adc_status_reg.sv
module adc_status_reg
  import adc_stat_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_done_i,
  input  logic              mode_wr_i,
  input  logic              pri_wr_i,
  input  logic              pri_under_i,
  input  logic              pri_over_i,
  input  logic [DW-1:0]     pri_data_i,
  input  logic              aux_wr_i,
  input  logic              aux_under_i,
  input  logic              aux_over_i,
  input  logic [DW-1:0]     aux_data_i,
  input  logic              pri_rd_i,
  input  logic              aux_rd_i,
  input  logic [AW-1:0]     acc_val_i,
  input  logic [AW-1:0]     acc_thr_i,
  input  logic              cmp_en_i,
  input  logic              cnt_en_i,
  input  logic [DW-1:0]     thr_val_i,
  input  logic [CW-1:0]     thr_cnt_i,
  input  logic              ovr_en_i,
  input  logic              ovr_tick_i,
  input  logic              ovr_sample_i,
  input  logic              gain_wr_i,
  output logic [DW-1:0]     pri_dat_o,
  output logic [DW-1:0]     aux_dat_o,
  output logic [STAT_W-1:0] status_o
);
  logic [N_CH-1:0]         ch_wr, ch_under, ch_over, ch_err;
  logic [N_CH-1:0][DW-1:0] ch_data, ch_clamp, ch_dat;

  assign ch_wr[CH_PRI]    = pri_wr_i;
  assign ch_wr[CH_AUX]    = aux_wr_i;
  assign ch_under[CH_PRI] = pri_under_i;
  assign ch_under[CH_AUX] = aux_under_i;
  assign ch_over[CH_PRI]  = pri_over_i;
  assign ch_over[CH_AUX]  = aux_over_i;
  assign ch_data[CH_PRI]  = pri_data_i;
  assign ch_data[CH_AUX]  = aux_data_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    adc_result_chan #(.DW(DW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (ch_wr[g]),
      .under_i (ch_under[g]),
      .over_i  (ch_over[g]),
      .data_i  (ch_data[g]),
      .clamp_o (ch_clamp[g]),
      .dat_o   (ch_dat[g]),
      .err_o   (ch_err[g])
    );
  end

  assign pri_dat_o = ch_dat[CH_PRI];
  assign aux_dat_o = ch_dat[CH_AUX];

  logic thr_flag, ovr_flag;

  adc_thresh_qual #(.DW(DW), .CW(CW)) u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (pri_wr_i),
    .cmp_en_i  (cmp_en_i),
    .cnt_en_i  (cnt_en_i),
    .val_i     (ch_clamp[CH_PRI]),
    .thr_i     (thr_val_i),
    .cnt_lim_i (thr_cnt_i),
    .flag_o    (thr_flag)
  );

  adc_ovr_detect u_ovr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ovr_en_i),
    .tick_i    (ovr_tick_i),
    .sample_i  (ovr_sample_i),
    .gain_wr_i (gain_wr_i),
    .flag_o    (ovr_flag)
  );

  logic cal_q, prdy_q, ardy_q, aux_armed_q, acc_gt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q       <= 1'b0;
      prdy_q      <= 1'b0;
      ardy_q      <= 1'b0;
      aux_armed_q <= 1'b0;
      acc_gt_q    <= 1'b0;
    end else begin
      acc_gt_q <= acc_val_i > acc_thr_i;

      if (cal_done_i)     cal_q <= 1'b1;
      else if (mode_wr_i) cal_q <= 1'b0;

      if (pri_wr_i || cal_done_i) prdy_q <= 1'b1;
      else if (pri_rd_i)          prdy_q <= 1'b0;

      // aux ready needs an aux read in an earlier cycle than the primary read
      if (aux_wr_i || cal_done_i)     ardy_q <= 1'b1;
      else if (pri_rd_i && aux_armed_q) ardy_q <= 1'b0;

      if (aux_rd_i)      aux_armed_q <= 1'b1;
      else if (pri_rd_i) aux_armed_q <= 1'b0;
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[B_CAL]  = cal_q;
    status_o[B_AERR] = ch_err[CH_AUX];
    status_o[B_PERR] = ch_err[CH_PRI];
    status_o[B_ACC]  = acc_gt_q;
    status_o[B_THR]  = thr_flag;
    status_o[B_OVR]  = ovr_flag;
    status_o[B_ARDY] = ardy_q;
    status_o[B_PRDY] = prdy_q;
  end
endmodule

// File: rtl/adc_status_chk.sv
module adc_status_chk
  import adc_stat_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cal_done_i,
  input logic              pri_wr_i,
  input logic              pri_under_i,
  input logic              pri_over_i,
  input logic              pri_rd_i,
  input logic              aux_wr_i,
  input logic              ovr_en_i,
  input logic              gain_wr_i,
  input logic [DW-1:0]     pri_dat_o,
  input logic [STAT_W-1:0] status_o
);
  localparam logic [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};

  a_r1_cal_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_i |=> status_o[B_CAL]);

  a_r2_over_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_wr_i && pri_over_i && !pri_under_i) |=> (pri_dat_o == POS_FS));

  a_r3_err_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_wr_i && !pri_under_i && !pri_over_i) |=> !status_o[B_PERR]);

  a_r5_rdy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_rd_i && !pri_wr_i && !cal_done_i) |=> !status_o[B_PRDY]);

  a_r6_ardy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[B_ARDY] && !pri_rd_i) |=> status_o[B_ARDY]);

  a_r9_ovr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[B_OVR] && ovr_en_i && !gain_wr_i) |=> status_o[B_OVR]);
endmodule

bind adc_status_reg adc_status_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cal_done_i  (cal_done_i),
  .pri_wr_i    (pri_wr_i),
  .pri_under_i (pri_under_i),
  .pri_over_i  (pri_over_i),
  .pri_rd_i    (pri_rd_i),
  .aux_wr_i    (aux_wr_i),
  .ovr_en_i    (ovr_en_i),
  .gain_wr_i   (gain_wr_i),
  .pri_dat_o   (pri_dat_o),
  .status_o    (status_o)
);

// File: tb/adc_status_reg_bench.sv
module adc_status_reg_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cal_done_i = 0, mode_wr_i = 0;
  logic        pri_wr_i = 0, pri_under_i = 0, pri_over_i = 0;
  logic [15:0] pri_data_i = '0;
  logic        aux_wr_i = 0, aux_under_i = 0, aux_over_i = 0;
  logic [15:0] aux_data_i = '0;
  logic        pri_rd_i = 0, aux_rd_i = 0;
  logic [15:0] acc_val_i = '0, acc_thr_i = '0;
  logic        cmp_en_i = 0, cnt_en_i = 0;
  logic [15:0] thr_val_i = '0;
  logic [7:0]  thr_cnt_i = '0;
  logic        ovr_en_i = 0, ovr_tick_i = 0, ovr_sample_i = 0, gain_wr_i = 0;
  logic [15:0] pri_dat_o, aux_dat_o, status_o;

  always #5 clk_i = ~clk_i;

  adc_status_reg u_adc_status_reg (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct packed {
    logic        under;
    logic        over;
    logic [15:0] data;
    logic [15:0] exp_dat;
    logic        exp_err;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{1'b0, 1'b0, 16'h1234, 16'h1234, 1'b0},
    '{1'b1, 1'b0, 16'h0100, 16'h8000, 1'b1},
    '{1'b0, 1'b0, 16'hFFF0, 16'hFFF0, 1'b0},
    '{1'b0, 1'b1, 16'h0001, 16'h7FFF, 1'b1},
    '{1'b0, 1'b1, 16'h0000, 16'h7FFF, 1'b1},
    '{1'b1, 1'b1, 16'h5555, 16'h8000, 1'b1},
    '{1'b0, 1'b0, 16'h8001, 16'h8001, 1'b0}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic quiet();
    cal_done_i = 0; mode_wr_i = 0; pri_wr_i = 0; aux_wr_i = 0;
    pri_rd_i = 0; aux_rd_i = 0; gain_wr_i = 0; ovr_tick_i = 0;
  endtask

  task automatic pri_write(logic [15:0] d, logic u, logic o);
    pri_data_i = d; pri_under_i = u; pri_over_i = o; pri_wr_i = 1;
    step(); quiet();
    pri_under_i = 0; pri_over_i = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    #23 rst_ni = 1'b1;
    step();
    check("reset status", status_o, 16'h0000);
    check("reset data", {pri_dat_o, aux_dat_o}, 32'h0);

    // R2/R3/R5 table walk on both channels
    foreach (TBL[i]) begin
      pri_write(TBL[i].data, TBL[i].under, TBL[i].over);
      check($sformatf("R2 pri vec%0d", i), pri_dat_o, TBL[i].exp_dat);
      check($sformatf("R3 pri err vec%0d", i), status_o[12], TBL[i].exp_err);
      check($sformatf("R5 pri rdy vec%0d", i), status_o[0], 1'b1);
      aux_data_i = TBL[i].data; aux_under_i = TBL[i].under; aux_over_i = TBL[i].over;
      aux_wr_i = 1; step(); quiet(); aux_under_i = 0; aux_over_i = 0;
      check($sformatf("R2 aux vec%0d", i), aux_dat_o, TBL[i].exp_dat);
      check($sformatf("R3 aux err vec%0d", i), status_o[13], TBL[i].exp_err);
    end
    // R3: aux error unaffected by primary writes
    aux_over_i = 1; aux_wr_i = 1; step(); quiet(); aux_over_i = 0;
    pri_write(16'h0001, 0, 0);
    check("R3 aux err kept", status_o[13], 1'b1);

    // R1
    cal_done_i = 1; step(); quiet();
    check("R1 cal set", status_o[15], 1'b1);
    check("R5 cal sets rdy", status_o[0], 1'b1);
    check("R10 reserved zero", status_o & 16'h4FA4, 16'h0);
    mode_wr_i = 1; step(); quiet();
    check("R1 mode clears", status_o[15], 1'b0);
    cal_done_i = 1; mode_wr_i = 1; step(); quiet();
    check("R1 set wins", status_o[15], 1'b1);

    // R5
    pri_rd_i = 1; step(); quiet();
    check("R5 read clears", status_o[0], 1'b0);
    pri_rd_i = 1; pri_wr_i = 1; step(); quiet();
    check("R5 set wins", status_o[0], 1'b1);

    // R6
    aux_wr_i = 1; step(); quiet();
    pri_rd_i = 1; step(); quiet();
    check("R6 pri read alone", status_o[1], 1'b1);
    aux_rd_i = 1; step(); quiet();
    check("R6 aux read alone", status_o[1], 1'b1);
    pri_rd_i = 1; step(); quiet();
    check("R6 ordered clear", status_o[1], 1'b0);
    aux_wr_i = 1; step(); quiet();
    aux_rd_i = 1; pri_rd_i = 1; step(); quiet();
    check("R6 same cycle", status_o[1], 1'b1);
    pri_rd_i = 1; step(); quiet();
    check("R6 armed clear", status_o[1], 1'b0);
    aux_rd_i = 1; step(); quiet();
    aux_wr_i = 1; pri_rd_i = 1; step(); quiet();
    check("R6 set wins", status_o[1], 1'b1);

    // R4
    acc_val_i = 16'd100; acc_thr_i = 16'd50; step();
    check("R4 above", status_o[6], 1'b1);
    acc_val_i = 16'd50; step();
    check("R4 equal", status_o[6], 1'b0);
    acc_val_i = 16'hFFFF; acc_thr_i = 16'h0001; step();
    check("R4 unsigned", status_o[6], 1'b1);
    acc_val_i = 16'd0; step();
    check("R4 live drop", status_o[6], 1'b0);

    // R7
    pri_write(16'h7000, 0, 0);
    check("R7 cmp off", status_o[4], 1'b0);
    cmp_en_i = 1; thr_val_i = 16'h0100;
    pri_write(16'h0101, 0, 0);
    check("R7 above", status_o[4], 1'b1);
    pri_write(16'h0100, 0, 0);
    check("R7 equal", status_o[4], 1'b0);
    pri_write(16'hFEFF, 0, 0);
    check("R7 negative", status_o[4], 1'b1);
    pri_write(16'hFF00, 0, 0);
    check("R7 neg equal", status_o[4], 1'b0);
    pri_write(16'h0000, 1, 0);
    check("R7 clamped min", status_o[4], 1'b1);
    cmp_en_i = 0; step();
    check("R7 disable", status_o[4], 1'b0);

    // R8
    cmp_en_i = 1; cnt_en_i = 1; thr_cnt_i = 8'd3;
    pri_write(16'h0200, 0, 0);
    check("R8 run1", status_o[4], 1'b0);
    pri_write(16'h0200, 0, 0);
    check("R8 run2", status_o[4], 1'b0);
    pri_write(16'h0200, 0, 0);
    check("R8 run3", status_o[4], 1'b1);
    pri_write(16'h0200, 0, 0);
    check("R8 run4", status_o[4], 1'b1);
    pri_write(16'h0010, 0, 0);
    check("R8 break", status_o[4], 1'b0);
    pri_write(16'h0200, 0, 0);
    check("R8 restart", status_o[4], 1'b0);
    cmp_en_i = 0; cnt_en_i = 0; step();

    // R9
    ovr_en_i = 1; ovr_tick_i = 1; step(); quiet();
    check("R9 tick no sample", status_o[3], 1'b0);
    ovr_sample_i = 1; step();
    check("R9 sample no tick", status_o[3], 1'b0);
    ovr_tick_i = 1; step(); quiet();
    check("R9 set", status_o[3], 1'b1);
    ovr_sample_i = 0; ovr_tick_i = 1; step(); quiet();
    check("R9 sticky", status_o[3], 1'b1);
    gain_wr_i = 1; step(); quiet();
    check("R9 gain clears", status_o[3], 1'b0);
    ovr_sample_i = 1; ovr_tick_i = 1; gain_wr_i = 1; step(); quiet();
    check("R9 set wins", status_o[3], 1'b1);
    ovr_en_i = 0; step();
    check("R9 disable clears", status_o[3], 1'b0);
    ovr_tick_i = 1; step(); quiet();
    check("R9 disabled no set", status_o[3], 1'b0);
    ovr_sample_i = 0;

    // R10 with many flags up
    cal_done_i = 1; pri_over_i = 1; pri_wr_i = 1; aux_under_i = 1; aux_wr_i = 1;
    acc_val_i = 16'd9; step(); quiet(); pri_over_i = 0; aux_under_i = 0;
    check("R10 reserved zero busy", status_o & 16'h4FA4, 16'h0);

    done = 1;
    summary();
  end
endmodule